// File: doc/BRIEF.md
# Operand-Waiting Issue Queue with Result-Bus Wakeup

This block sits in front of a single functional unit in an out-of-order core. It holds a small set of slots for instructions that have been issued but cannot yet execute. Each issued instruction brings an operation code and the reorder-buffer slot that will receive its result. It also brings, for each of its two sources, either the operand value or the reorder-buffer slot number of the instruction that will produce it.

Slots with an outstanding source watch the shared result bus. When a broadcast carries the awaited slot number, they latch its value. Once a slot holds both operand values it becomes a candidate for execution. The lowest-numbered candidate is sent to the functional unit, one per cycle. A slot stays occupied after it has been sent and is released only when the unit broadcasts the result for that slot's destination. A flush empties every slot at once.

Top module: `rs_pool`

## Requirements
- R1: `iss_ready_o` is high exactly when at least one slot is free and `rob_free_i` is high. An issue is accepted when `iss_valid_i` and `iss_ready_o` are both high, and the instruction goes into the lowest-numbered free slot.
- R2: While `rob_free_i` is low no instruction is accepted, so no slot is taken and nothing is later dispatched from that attempt.
- R3: Each source is given at issue either as a value (`*_rdy_i` = 1, value on `*_val_i`) or as a producer tag (`*_rdy_i` = 0, tag on `*_tag_i`). The dispatched opcode and destination equal the issued ones.
- R4: A slot with a pending source takes `bus_val_i` into that source in a cycle where `bus_valid_i` is high and `bus_tag_i` equals the source's tag.
- R5: A pending source whose tag matches a valid bus broadcast in its own issue cycle takes the broadcast value and does not stay pending.
- R6: A slot is dispatched only when both of its sources hold values. `disp_valid_o` rises in the cycle after the second value arrives and presents op, destination and both operands.
- R7: When several slots are ready, `disp_idx_o` names the lowest-numbered one. One slot is dispatched per cycle, and a dispatched slot is never presented again.
- R8: A dispatched slot becomes free in the cycle after a valid bus broadcast carries its destination tag. It can then receive a new issue.
- R9: `flush_i` frees all slots in the following cycle, and any issue presented in the flush cycle is discarded.
- R10: After reset all slots are free and `disp_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Frees all slots |
| rob_free_i | input | 1 | A reorder-buffer slot is available |
| iss_valid_i | input | 1 | Issue request |
| iss_op_i | input | OP_W | Operation code |
| iss_dst_i | input | TAG_W | Destination reorder-buffer slot |
| iss_s1_rdy_i | input | 1 | Source 1 given as value |
| iss_s1_val_i | input | DATA_W | Source 1 value |
| iss_s1_tag_i | input | TAG_W | Source 1 producer tag |
| iss_s2_rdy_i | input | 1 | Source 2 given as value |
| iss_s2_val_i | input | DATA_W | Source 2 value |
| iss_s2_tag_i | input | TAG_W | Source 2 producer tag |
| iss_ready_o | output | 1 | Issue can be accepted |
| bus_valid_i | input | 1 | Result broadcast valid |
| bus_tag_i | input | TAG_W | Broadcast reorder-buffer slot |
| bus_val_i | input | DATA_W | Broadcast value |
| disp_valid_o | output | 1 | An instruction is sent to the unit |
| disp_idx_o | output | IDX_W | Slot being dispatched |
| disp_op_o | output | OP_W | Dispatched operation code |
| disp_dst_o | output | TAG_W | Dispatched destination tag |
| disp_a_o | output | DATA_W | Dispatched operand 1 |
| disp_b_o | output | DATA_W | Dispatched operand 2 |

## Verification
The hardest situation to reach is several slots becoming ready in the same cycle, because random traffic wakes slots one at a time. A directed sequence fills every slot with a source that waits on one shared tag. A single broadcast then wakes them all together, so the bench can observe the lowest-first order of dispatch and the pool-full stall. The same-cycle capture at issue is also driven directly by issuing with a tag that the bus carries in that cycle. Long random traffic follows. In it, broadcasts mostly target the destinations of dispatched slots so that slots recycle, and occasional flushes are mixed in.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // descending scan: the last hit written is the lowest index
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IDX_W'(i);
        any_o    = 1'b1;
      end
    end
  end

  always_comb begin
    p_single_grant_r7 : assert ($onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
  end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rs_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_dst_i,
  input  logic              iss_r1_i,
  input  logic [DATA_W-1:0] iss_v1_i,
  input  logic [TAG_W-1:0]  iss_t1_i,
  input  logic              iss_r2_i,
  input  logic [DATA_W-1:0] iss_v2_i,
  input  logic [TAG_W-1:0]  iss_t2_i,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_val_i,
  input  logic              grant_i,
  output logic              free_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [TAG_W-1:0]  dst_o,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);
  slot_state_e       st_q, st_d;
  logic              r1_q, r1_d, r2_q, r2_d;
  logic [DATA_W-1:0] v1_q, v1_d, v2_q, v2_d;
  logic [TAG_W-1:0]  t1_q, t1_d, t2_q, t2_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [TAG_W-1:0]  dst_q, dst_d;
  logic              en;

  logic new_hit1, new_hit2, old_hit1, old_hit2, done_hit;
  assign new_hit1 = bus_valid_i && (bus_tag_i == iss_t1_i);
  assign new_hit2 = bus_valid_i && (bus_tag_i == iss_t2_i);
  assign old_hit1 = bus_valid_i && (bus_tag_i == t1_q) && !r1_q;
  assign old_hit2 = bus_valid_i && (bus_tag_i == t2_q) && !r2_q;
  assign done_hit = bus_valid_i && (bus_tag_i == dst_q);

  always_comb begin
    st_d = st_q; op_d = op_q; dst_d = dst_q;
    r1_d = r1_q; v1_d = v1_q; t1_d = t1_q;
    r2_d = r2_q; v2_d = v2_q; t2_d = t2_q;
    if (flush_i) begin
      st_d = SLOT_FREE;
    end else begin
      unique case (st_q)
        SLOT_FREE: if (alloc_i) begin
          st_d  = SLOT_WAIT;
          op_d  = iss_op_i;
          dst_d = iss_dst_i;
          t1_d  = iss_t1_i;
          t2_d  = iss_t2_i;
          r1_d  = iss_r1_i || new_hit1;
          r2_d  = iss_r2_i || new_hit2;
          v1_d  = iss_r1_i ? iss_v1_i : bus_val_i;
          v2_d  = iss_r2_i ? iss_v2_i : bus_val_i;
        end
        SLOT_WAIT: begin
          if (old_hit1) begin r1_d = 1'b1; v1_d = bus_val_i; end
          if (old_hit2) begin r2_d = 1'b1; v2_d = bus_val_i; end
          if (grant_i) st_d = SLOT_EXEC;
        end
        SLOT_EXEC: if (done_hit) st_d = SLOT_FREE;
        default: st_d = SLOT_FREE;
      endcase
    end
  end

  assign en = flush_i || alloc_i || (st_q != SLOT_FREE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SLOT_FREE; op_q <= '0; dst_q <= '0;
      r1_q <= 1'b0; v1_q <= '0; t1_q <= '0;
      r2_q <= 1'b0; v2_q <= '0; t2_q <= '0;
    end else if (en) begin
      st_q <= st_d; op_q <= op_d; dst_q <= dst_d;
      r1_q <= r1_d; v1_q <= v1_d; t1_q <= t1_d;
      r2_q <= r2_d; v2_q <= v2_d; t2_q <= t2_d;
    end
  end

  assign free_o  = (st_q == SLOT_FREE);
  assign ready_o = (st_q == SLOT_WAIT) && r1_q && r2_q;
  assign op_o    = op_q;
  assign dst_o   = dst_q;
  assign a_o     = v1_q;
  assign b_o     = v2_q;

  p_go_needs_ops_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    grant_i |-> (st_q == SLOT_WAIT && r1_q && r2_q));
  p_flush_frees_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (st_q == SLOT_FREE));
  p_wakeup_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && st_q == SLOT_WAIT && old_hit1) |=> (r1_q && v1_q == $past(bus_val_i)));
  p_issue_catch_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && alloc_i && st_q == SLOT_FREE && !iss_r2_i && new_hit2)
      |=> (r2_q && v2_q == $past(bus_val_i)));
  p_release_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && st_q == SLOT_EXEC && done_hit) |=> (st_q == SLOT_FREE));
endmodule

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int N      = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int OP_W   = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              rob_free_i,
  input  logic              iss_valid_i,
  input  logic [OP_W-1:0]   iss_op_i,
  input  logic [TAG_W-1:0]  iss_dst_i,
  input  logic              iss_s1_rdy_i,
  input  logic [DATA_W-1:0] iss_s1_val_i,
  input  logic [TAG_W-1:0]  iss_s1_tag_i,
  input  logic              iss_s2_rdy_i,
  input  logic [DATA_W-1:0] iss_s2_val_i,
  input  logic [TAG_W-1:0]  iss_s2_tag_i,
  output logic              iss_ready_o,
  input  logic              bus_valid_i,
  input  logic [TAG_W-1:0]  bus_tag_i,
  input  logic [DATA_W-1:0] bus_val_i,
  output logic              disp_valid_o,
  output logic [IDX_W-1:0]  disp_idx_o,
  output logic [OP_W-1:0]   disp_op_o,
  output logic [TAG_W-1:0]  disp_dst_o,
  output logic [DATA_W-1:0] disp_a_o,
  output logic [DATA_W-1:0] disp_b_o
);
  logic [N-1:0]      free_vec, rdy_vec, alloc_gnt, go_gnt;
  logic [IDX_W-1:0]  alloc_idx, go_idx;
  logic              any_free, any_rdy, iss_fire;
  logic [OP_W-1:0]   op_a  [N];
  logic [TAG_W-1:0]  dst_a [N];
  logic [DATA_W-1:0] a_a   [N];
  logic [DATA_W-1:0] b_a   [N];

  rs_pick #(.N(N), .IDX_W(IDX_W)) u_free_pick (
    .req_i(free_vec), .gnt_o(alloc_gnt), .idx_o(alloc_idx), .any_o(any_free));
  rs_pick #(.N(N), .IDX_W(IDX_W)) u_go_pick (
    .req_i(rdy_vec), .gnt_o(go_gnt), .idx_o(go_idx), .any_o(any_rdy));

  assign iss_ready_o = any_free && rob_free_i;
  assign iss_fire    = iss_valid_i && iss_ready_o && !flush_i;

  for (genvar g = 0; g < N; g++) begin : g_slot
    rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
      .alloc_i(iss_fire && alloc_gnt[g]),
      .iss_op_i(iss_op_i), .iss_dst_i(iss_dst_i),
      .iss_r1_i(iss_s1_rdy_i), .iss_v1_i(iss_s1_val_i), .iss_t1_i(iss_s1_tag_i),
      .iss_r2_i(iss_s2_rdy_i), .iss_v2_i(iss_s2_val_i), .iss_t2_i(iss_s2_tag_i),
      .bus_valid_i(bus_valid_i), .bus_tag_i(bus_tag_i), .bus_val_i(bus_val_i),
      .grant_i(go_gnt[g]),
      .free_o(free_vec[g]), .ready_o(rdy_vec[g]),
      .op_o(op_a[g]), .dst_o(dst_a[g]), .a_o(a_a[g]), .b_o(b_a[g]));
  end

  assign disp_valid_o = any_rdy;
  assign disp_idx_o   = go_idx;
  assign disp_op_o    = op_a[go_idx];
  assign disp_dst_o   = dst_a[go_idx];
  assign disp_a_o     = a_a[go_idx];
  assign disp_b_o     = b_a[go_idx];

  p_no_take_without_rob_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    (!rob_free_i && !flush_i) |=> ($countones(free_vec) >= $past($countones(free_vec))));
  p_issue_lands_free_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (iss_fire) |=> !free_vec[$past(alloc_idx)]);
  p_sent_not_repeated_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (any_rdy && !flush_i) |=> !rdy_vec[$past(go_idx)]);
endmodule

// File: tb/rs_pool_tb_top.sv
module rs_pool_tb_top;
  localparam int N = 4, TAG_W = 3, DATA_W = 16, OP_W = 4, IDX_W = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic flush, rob_free, iss_valid;
  logic [OP_W-1:0] iss_op;
  logic [TAG_W-1:0] iss_dst, s1_tag, s2_tag, bus_tag;
  logic s1_rdy, s2_rdy, bus_valid;
  logic [DATA_W-1:0] s1_val, s2_val, bus_val;
  logic iss_ready, disp_valid;
  logic [IDX_W-1:0] disp_idx;
  logic [OP_W-1:0] disp_op;
  logic [TAG_W-1:0] disp_dst;
  logic [DATA_W-1:0] disp_a, disp_b;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model: 0 free, 1 waiting, 2 sent
  int m_st [N];
  logic [OP_W-1:0] m_op [N];
  logic [TAG_W-1:0] m_dst [N], m_t1 [N], m_t2 [N];
  logic m_r1 [N], m_r2 [N];
  logic [DATA_W-1:0] m_v1 [N], m_v2 [N];

  always #4 clk = ~clk;

  rs_pool #(.N(N), .TAG_W(TAG_W), .DATA_W(DATA_W), .OP_W(OP_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush), .rob_free_i(rob_free),
    .iss_valid_i(iss_valid), .iss_op_i(iss_op), .iss_dst_i(iss_dst),
    .iss_s1_rdy_i(s1_rdy), .iss_s1_val_i(s1_val), .iss_s1_tag_i(s1_tag),
    .iss_s2_rdy_i(s2_rdy), .iss_s2_val_i(s2_val), .iss_s2_tag_i(s2_tag),
    .iss_ready_o(iss_ready), .bus_valid_i(bus_valid), .bus_tag_i(bus_tag),
    .bus_val_i(bus_val), .disp_valid_o(disp_valid), .disp_idx_o(disp_idx),
    .disp_op_o(disp_op), .disp_dst_o(disp_dst), .disp_a_o(disp_a), .disp_b_o(disp_b));

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < N; i++) if (m_st[i] == 0) return i;
    return -1;
  endfunction

  function automatic int lowest_ready();
    for (int i = 0; i < N; i++) if (m_st[i] == 1 && m_r1[i] && m_r2[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    flush = 0; rob_free = 1; iss_valid = 0; iss_op = '0; iss_dst = '0;
    s1_rdy = 1; s1_val = '0; s1_tag = '0; s2_rdy = 1; s2_val = '0; s2_tag = '0;
    bus_valid = 0; bus_tag = '0; bus_val = '0;
  endtask

  task automatic compare();
    int fi, ri;
    fi = lowest_free();
    ri = lowest_ready();
    chk("R1", "iss_ready", iss_ready, (fi >= 0 && rob_free) ? 1 : 0);
    chk("R6", "disp_valid", disp_valid, (ri >= 0) ? 1 : 0);
    if (ri >= 0) begin
      chk("R7", "disp_idx", disp_idx, ri);
      chk("R3", "disp_op", disp_op, m_op[ri]);
      chk("R3", "disp_dst", disp_dst, m_dst[ri]);
      chk("R4", "disp_a", disp_a, m_v1[ri]);
      chk("R4", "disp_b", disp_b, m_v2[ri]);
    end
  endtask

  task automatic model_update();
    int fi, ri;
    bit fire;
    fi = lowest_free();
    ri = lowest_ready();
    if (flush) begin
      for (int i = 0; i < N; i++) m_st[i] = 0;
      return;
    end
    fire = iss_valid && rob_free && (fi >= 0);
    for (int i = 0; i < N; i++) begin
      if (m_st[i] == 2 && bus_valid && bus_tag == m_dst[i]) m_st[i] = 0;
      else if (m_st[i] == 1) begin
        if (!m_r1[i] && bus_valid && bus_tag == m_t1[i]) begin m_r1[i] = 1; m_v1[i] = bus_val; end
        if (!m_r2[i] && bus_valid && bus_tag == m_t2[i]) begin m_r2[i] = 1; m_v2[i] = bus_val; end
      end
    end
    if (ri >= 0) m_st[ri] = 2;
    if (fire) begin
      m_st[fi] = 1; m_op[fi] = iss_op; m_dst[fi] = iss_dst;
      m_t1[fi] = s1_tag; m_t2[fi] = s2_tag;
      m_r1[fi] = s1_rdy || (bus_valid && bus_tag == s1_tag);
      m_r2[fi] = s2_rdy || (bus_valid && bus_tag == s2_tag);
      m_v1[fi] = s1_rdy ? s1_val : bus_val;
      m_v2[fi] = s2_rdy ? s2_val : bus_val;
    end
  endtask

  task automatic step();
    #1;
    compare();
    model_update();
    @(negedge clk);
  endtask

  task automatic probe();
    idle();
    #1;
  endtask

  task automatic put(input logic [OP_W-1:0] op, input logic [TAG_W-1:0] dst,
                     input logic r1, input logic [DATA_W-1:0] v1, input logic [TAG_W-1:0] t1,
                     input logic r2, input logic [DATA_W-1:0] v2, input logic [TAG_W-1:0] t2);
    iss_valid = 1; iss_op = op; iss_dst = dst;
    s1_rdy = r1; s1_val = v1; s1_tag = t1;
    s2_rdy = r2; s2_val = v2; s2_tag = t2;
  endtask

  function automatic logic [TAG_W-1:0] sent_tag();
    int cnt, pick;
    cnt = 0;
    for (int i = 0; i < N; i++) if (m_st[i] == 2) cnt++;
    if (cnt == 0) return TAG_W'($urandom);
    pick = $urandom % cnt;
    for (int i = 0; i < N; i++) if (m_st[i] == 2) begin
      if (pick == 0) return m_dst[i];
      pick--;
    end
    return '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1D5E_ED01));
    idle();
    rst_n = 0;
    for (int i = 0; i < N; i++) begin
      m_st[i] = 0; m_r1[i] = 0; m_r2[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: reset state
    probe();
    chk("R10", "iss_ready after reset", iss_ready, 1);
    chk("R10", "disp_valid after reset", disp_valid, 0);

    // R2: blocked by reorder buffer
    rob_free = 0; put(4'h1, 3'd6, 1, 16'h1111, 0, 1, 16'h2222, 0);
    step();
    probe();
    chk("R2", "disp_valid after blocked issue", disp_valid, 0);

    // R5: same-cycle capture at issue
    put(4'h3, 3'd1, 0, 16'h0, 3'd5, 1, 16'h0011, 0);
    bus_valid = 1; bus_tag = 3'd5; bus_val = 16'hABCD;
    step();
    probe();
    chk("R5", "disp_valid after issue-cycle capture", disp_valid, 1);
    chk("R5", "captured operand", disp_a, 16'hABCD);
    chk("R5", "ready operand", disp_b, 16'h0011);
    step();
    bus_valid = 1; bus_tag = 3'd1; bus_val = 16'h0;
    step();

    // R7: fill, wake all at once, lowest first
    for (int k = 0; k < N; k++) begin
      idle();
      put(OP_W'(k + 8), TAG_W'(k), 0, 16'h0, 3'd7, 1, DATA_W'(k), 0);
      step();
    end
    probe();
    chk("R1", "iss_ready with pool full", iss_ready, 0);
    chk("R6", "disp_valid while waiting", disp_valid, 0);
    bus_valid = 1; bus_tag = 3'd7; bus_val = 16'h7777;
    step();
    for (int k = 0; k < N; k++) begin
      probe();
      chk("R7", "dispatch order", disp_idx, k);
      chk("R4", "woken operand", disp_a, 16'h7777);
      step();
    end
    probe();
    chk("R7", "no repeat dispatch", disp_valid, 0);

    // R8: release on writeback
    bus_valid = 1; bus_tag = 3'd2; bus_val = 16'h0;
    step();
    probe();
    chk("R8", "iss_ready after release", iss_ready, 1);
    put(4'h5, 3'd4, 1, 16'h5555, 0, 1, 16'h6666, 0);
    step();
    probe();
    chk("R8", "reused slot", disp_idx, 2);

    // R9: flush with a concurrent issue
    flush = 1; put(4'h6, 3'd5, 1, 16'h1, 0, 1, 16'h2, 0);
    step();
    for (int i = 0; i < N; i++) m_st[i] = 0;
    probe();
    chk("R9", "disp_valid after flush", disp_valid, 0);
    chk("R9", "iss_ready after flush", iss_ready, 1);
    put(4'h7, 3'd3, 1, 16'hBEEF, 0, 1, 16'hCAFE, 0);
    step();
    probe();
    chk("R9", "first slot after flush", disp_idx, 0);
    chk("R9", "operand after flush", disp_a, 16'hBEEF);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      idle();
      flush = ($urandom % 64) == 0;
      rob_free = ($urandom % 100) < 85;
      iss_valid = ($urandom % 100) < 60;
      iss_op = OP_W'($urandom); iss_dst = TAG_W'($urandom);
      s1_rdy = $urandom % 2; s1_val = DATA_W'($urandom); s1_tag = TAG_W'($urandom);
      s2_rdy = $urandom % 2; s2_val = DATA_W'($urandom); s2_tag = TAG_W'($urandom);
      bus_valid = $urandom % 2;
      bus_tag = (($urandom % 10) < 6) ? sent_tag() : TAG_W'($urandom);
      bus_val = DATA_W'($urandom);
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule